// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block holds the payload of SMBus block transactions in a small byte array that the host reaches through one data port register. In buffer mode each access to the port moves an internal host pointer one entry forward, so a block is loaded by writing the port repeatedly and unloaded by reading it repeatedly. A read of the host control register returns the pointer to entry zero, ready for the next pass.

The transaction sequencer on the other side has its own pointer. It is returned to zero by a start pulse. It pushes the bytes it receives from the slave, pops the bytes it must transmit, and hands over the count byte the slave reported. The count lives in a separate count register, which the host can also read and write. A received count outside 1 to DEPTH raises a device-error flag and blocks all stores until the next start.

An auxiliary control register holds two mode bits. One enables buffer mode and the other requests hardware packet-error checking. When buffer mode is off, the port behaves as a plain one-byte register and neither pointer moves.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the auxiliary register, the count register and the device-error flag are zero, `buf_en` and `pec_en` are low, and both pointers are at entry zero.
- R2: The auxiliary register sits at offset 13. Bit 1 drives `buf_en` and bit 0 drives `pec_en`. Bits 7..2 ignore writes and read as zero.
- R3: With buffer mode on, consecutive host writes to the port at offset 7 fill entries 0, 1, 2 and so on in order. After a pointer reset, consecutive port reads return those bytes in the same order.
- R4: A host read of the control register at offset 2 returns zero and sets the host pointer to entry zero.
- R5: The pointers do not wrap. Port writes beyond entry DEPTH-1 are dropped. Port reads beyond it return entry DEPTH-1 and leave the stored data unchanged.
- R6: With buffer mode off, port writes and reads reach entry 0 only and the host pointer does not move. When buffer mode is turned back on, the next host access lands on the entry the pointer held before.
- R7: The count register sits at offset 5. The host can read and write it, and its value always appears on `blk_count`.
- R8: A `seq_cnt_load` whose value lies in 1..DEPTH loads the count register. With buffer mode on and no device error, each `seq_wr` stores `seq_wdata` at the sequencer pointer and advances it from entry 0 after `seq_start`. With buffer mode off, `seq_wr` stores nothing.
- R9: A `seq_cnt_load` of 0 or above DEPTH sets `dev_err` on the next cycle and leaves the count register unchanged. Until the next `seq_start`, every `seq_wr` stores nothing. `seq_start` clears `dev_err`.
- R10: `seq_rdata` shows the entry at the sequencer pointer, clamped to DEPTH-1. Each `seq_rd` advances the pointer, starting from entry 0 after `seq_start`.
- R11: Offsets other than 2, 5, 7 and 13 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Host register offset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects apply at the clock edge) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from `reg_addr` |
| seq_start | input | 1 | Sequencer pulse: pointer to zero, clear device error |
| seq_cnt_load | input | 1 | Sequencer presents a received count |
| seq_cnt | input | 8 | Received count value |
| seq_wr | input | 1 | Sequencer stores a received byte |
| seq_wdata | input | 8 | Received byte |
| seq_rd | input | 1 | Sequencer consumes a byte to send |
| seq_rdata | output | 8 | Byte at the sequencer pointer |
| blk_count | output | 8 | Count register value |
| buf_en | output | 1 | Buffer mode enabled |
| pec_en | output | 1 | Packet-error checking requested |
| dev_err | output | 1 | Bad received count flag |

## Verification
The bench builds the block with its default DEPTH of 32, so one complete buffer fits in a short run. At that size the bench sweeps every received count from 0 to 40, which covers both invalid edges and every valid length. It also overruns the buffer by eight writes and two extra reads, which exercises the no-wrap clamp on both pointers. A mixed pass toggles buffer mode in the middle of a block, to show that the pointer is preserved and that the single-byte fallback uses entry 0.

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          seq_start,
  input  logic          seq_cnt_load,
  input  logic [DW-1:0] seq_cnt,
  input  logic          seq_wr,
  input  logic [DW-1:0] seq_wdata,
  input  logic          seq_rd,
  output logic [DW-1:0] seq_rdata,
  output logic [DW-1:0] blk_count,
  output logic          buf_en,
  output logic          pec_en,
  output logic          dev_err
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam int LAST = DEPTH - 1;
  localparam logic [3:0] OFS_CTRL = 4'd2;
  localparam logic [3:0] OFS_CNT  = 4'd5;
  localparam logic [3:0] OFS_PORT = 4'd7;
  localparam logic [3:0] OFS_AUX  = 4'd13;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] hidx, sidx;
  logic [1:0]    aux;
  logic [DW-1:0] cnt_q;
  logic          err_q;

  wire port_wr = reg_wr && reg_addr == OFS_PORT;
  wire port_rd = reg_rd && reg_addr == OFS_PORT;
  wire ctrl_rd = reg_rd && reg_addr == OFS_CTRL;
  wire h_room  = hidx < IW'(DEPTH);
  wire s_room  = sidx < IW'(DEPTH);
  wire cnt_ok  = seq_cnt != '0 && seq_cnt <= DW'(DEPTH);
  wire s_store = seq_wr && buf_en && !err_q && s_room;
  wire h_store = port_wr && (!buf_en || h_room);

  wire [IW-1:0] h_sel = !buf_en ? '0 : (h_room ? hidx : IW'(LAST));
  wire [IW-1:0] s_sel = s_room ? sidx : IW'(LAST);

  assign buf_en    = aux[1];
  assign pec_en    = aux[0];
  assign dev_err   = err_q;
  assign blk_count = cnt_q;
  assign seq_rdata = mem[s_sel[$clog2(DEPTH)-1:0]];

  always_comb begin
    unique case (reg_addr)
      OFS_CNT:  reg_rdata = cnt_q;
      OFS_PORT: reg_rdata = mem[h_sel[$clog2(DEPTH)-1:0]];
      OFS_AUX:  reg_rdata = {{(DW-2){1'b0}}, aux};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (s_store)
      mem[sidx[$clog2(DEPTH)-1:0]] <= seq_wdata;
    else if (h_store)
      mem[h_sel[$clog2(DEPTH)-1:0]] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hidx  <= '0;
      sidx  <= '0;
      aux   <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_AUX) aux <= reg_wdata[1:0];
      if (ctrl_rd)
        hidx <= '0;
      else if (buf_en && (port_wr || port_rd) && h_room)
        hidx <= hidx + 1'b1;
      if (seq_start) begin
        sidx  <= '0;
        err_q <= 1'b0;
      end else begin
        if (s_store || (seq_rd && s_room)) sidx <= sidx + 1'b1;
        if (seq_cnt_load && !cnt_ok) err_q <= 1'b1;
      end
      if (seq_cnt_load && cnt_ok)
        cnt_q <= seq_cnt;
      else if (reg_wr && reg_addr == OFS_CNT)
        cnt_q <= reg_wdata;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hidx <= IW'(DEPTH) && sidx <= IW'(DEPTH)); // R5
  AST_CTRL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> hidx == '0); // R4
  AST_NOBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !ctrl_rd && (port_wr || port_rd)) |=> $stable(hidx)); // R6
  AST_BADCNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_cnt_load && !cnt_ok && !seq_start && !(reg_wr && reg_addr == OFS_CNT))
      |=> dev_err && $stable(blk_count)); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !dev_err && sidx == '0); // R9
endmodule

// File: tb/smb_blkbuf_test.sv
module smb_blkbuf_test;
  localparam int PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic seq_start = 0, seq_cnt_load = 0, seq_wr = 0, seq_rd = 0;
  logic [7:0] seq_cnt = 0, seq_wdata = 0, seq_rdata, blk_count;
  logic buf_en, pec_en, dev_err;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #(PERIOD/2) clk = ~clk;

  smb_blkbuf #(.DEPTH(DEPTH), .DW(8)) uut (.*);

  function automatic logic [7:0] pat(int s, int i);
    return 8'((i * 37 + s * 11 + 5) & 8'hff);
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rewind();
    logic [7:0] z;
    rd(4'd2, z);
  endtask

  task automatic s_start();
    @(negedge clk); seq_start = 1; @(negedge clk); seq_start = 0;
  endtask

  task automatic s_cnt(logic [7:0] c);
    @(negedge clk); seq_cnt = c; seq_cnt_load = 1; @(negedge clk); seq_cnt_load = 0;
  endtask

  task automatic s_push(logic [7:0] v);
    @(negedge clk); seq_wdata = v; seq_wr = 1; @(negedge clk); seq_wr = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd13, d); chk("R1 aux", d, 8'h00);
    rd(4'd5, d);  chk("R1 count", d, 8'h00);
    chk("R1 flags", {5'b0, buf_en, pec_en, dev_err}, 8'h00);
    rd(4'd7, d);  rd(4'd7, d);
    // R2 aux register
    wr(4'd13, 8'hff); rd(4'd13, d); chk("R2 aux mask", d, 8'h03);
    chk("R2 outs", {6'b0, buf_en, pec_en}, 8'h03);
    wr(4'd13, 8'h02); chk("R2 pec off", {6'b0, buf_en, pec_en}, 8'h02);
    // R11 unmapped
    for (int a = 0; a < 16; a++)
      if (a != 2 && a != 5 && a != 7 && a != 13) begin
        rd(4'(a), d); chk("R11 unmapped", d, 8'h00);
      end
    // R3 R4 R7 host block load/drain
    for (int n = 1; n <= DEPTH; n += 3) begin
      wr(4'd5, 8'(n)); rd(4'd2, d); chk("R4 ctrl reads zero", d, 8'h00);
      for (int i = 0; i < n; i++) wr(4'd7, pat(n, i));
      rewind();
      for (int i = 0; i < n; i++) begin rd(4'd7, d); chk("R3 order", d, pat(n, i)); end
      rd(4'd5, d); chk("R7 count reg", d, 8'(n));
      chk("R7 blk_count", blk_count, 8'(n));
    end
    // R4 mid-block rewind
    rewind(); for (int i = 0; i < 5; i++) wr(4'd7, pat(99, i));
    rewind(); rd(4'd7, d); chk("R4 rewind", d, pat(99, 0));
    // R5 overrun
    rewind(); for (int i = 0; i < DEPTH + 8; i++) wr(4'd7, pat(7, i));
    rewind();
    for (int i = 0; i < DEPTH + 2; i++) begin
      rd(4'd7, d); chk("R5 clamp", d, pat(7, i < DEPTH ? i : DEPTH - 1));
    end
    // R6 disabled mode
    rewind(); for (int i = 0; i < 3; i++) wr(4'd7, pat(3, i));
    wr(4'd13, 8'h00);
    wr(4'd7, 8'ha5); rd(4'd7, d); chk("R6 single", d, 8'ha5);
    rd(4'd7, d); chk("R6 no advance", d, 8'ha5);
    wr(4'd13, 8'h02); wr(4'd7, 8'h5a);
    rewind();
    rd(4'd7, d); chk("R6 entry0", d, 8'ha5);
    rd(4'd7, d); chk("R6 entry1", d, pat(3, 1));
    rd(4'd7, d); chk("R6 entry2", d, pat(3, 2));
    rd(4'd7, d); chk("R6 held index", d, 8'h5a);
    // R8 valid counts
    for (int c = 1; c <= DEPTH; c++) begin
      s_start(); s_cnt(8'(c));
      chk("R8 no err", {7'b0, dev_err}, 8'h00);
      chk("R8 count", blk_count, 8'(c));
      for (int i = 0; i < c; i++) s_push(pat(c + 40, i));
      rewind();
      for (int i = 0; i < c; i++) begin rd(4'd7, d); chk("R8 data", d, pat(c + 40, i)); end
    end
    // R9 bad counts
    for (int c = 0; c <= 40; c++) begin
      if (c >= 1 && c <= DEPTH) continue;
      wr(4'd5, 8'h11);
      rewind(); for (int i = 0; i < 4; i++) wr(4'd7, pat(c, i));
      s_start(); s_cnt(8'(c));
      chk("R9 err set", {7'b0, dev_err}, 8'h01);
      chk("R9 count kept", blk_count, 8'h11);
      for (int i = 0; i < 4; i++) s_push(8'hee);
      rewind();
      for (int i = 0; i < 4; i++) begin rd(4'd7, d); chk("R9 no store", d, pat(c, i)); end
      s_start(); chk("R9 cleared", {7'b0, dev_err}, 8'h00);
    end
    // R8 sequencer ignored when disabled
    rewind(); for (int i = 0; i < 3; i++) wr(4'd7, pat(5, i));
    wr(4'd13, 8'h00); s_start(); s_cnt(8'd3);
    for (int i = 0; i < 3; i++) s_push(8'hcc);
    wr(4'd13, 8'h02); rewind();
    for (int i = 0; i < 3; i++) begin rd(4'd7, d); chk("R8 off ignored", d, pat(5, i)); end
    // R10 sequencer drain
    rewind(); for (int i = 0; i < DEPTH; i++) wr(4'd7, pat(9, i));
    s_start();
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk); #1 chk("R10 drain", seq_rdata, pat(9, i < DEPTH ? i : DEPTH - 1));
      seq_rd = 1; @(negedge clk); seq_rd = 0;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule